// File: doc/BRIEF.md
# Attribute Index Divider Unit

This block converts a linear thread index into the element index used to fetch a vertex or instance attribute. Each request carries its own mode and parameters, so neighbouring requests in a stream may use different modes. There are four modes. Pass-through is for draws without instancing. Modulo recovers a per-vertex index from a padded vertex count. Power-of-two division handles simple instance divisors. Magic-constant division handles any other divisor.

Magic-constant division never uses a general divider. It multiplies the index by a supplied 32-bit constant, whose top bit is always taken as one, and keeps the upper half of the product. An optional round-down step first adds one to the index. The result is then shifted right. Software derives the constant, the shift and the round-down flag from the divisor. Modulo mode reduces the modulus to a small odd factor and a power of two, so it only needs constant divides by 3, 5, 7 or 9.

The datapath has three register stages with a valid bit. It accepts a new request every cycle and returns results in order.

Top module: `attr_index_unit`

## Requirements
- R1: With `in_mode` = 2'b00 (pass-through), `out_index` equals `in_linear` unchanged, whatever the shift, extra and magic inputs hold.
- R2: With `in_mode` = 2'b10 (power-of-two divide), `out_index` equals `in_linear >> in_shift` for every shift from 0 to 31.
- R3: With `in_mode` = 2'b01 (modulo), `out_index` equals `in_linear mod ((2*in_extra+1) * 2^in_shift)` for `in_extra` from 0 to 4, including moduli larger than 2^32.
- R4: With `in_mode` = 2'b11 (magic divide) and `in_extra[0]` = 0, `out_index` equals `floor(in_linear * M / 2^32) >> in_shift`, where M is `in_magic` with bit 31 set.
- R5: With `in_mode` = 2'b11 and `in_extra[0]` = 1, the product uses `in_linear + 1` in 33-bit arithmetic, so `in_linear` = 0xFFFFFFFF gives no wrap.
- R6: In magic divide mode, the value stored in bit 31 of `in_magic` has no effect on `out_index`.
- R7: For any divisor d ≥ 3 that is not a power of two, the constants below make `out_index` equal `floor(in_linear / d)` for every 32-bit index. The constants are: shift = floor(log2 d), m = ceil(2^(shift+32)/d) and e = 2^(shift+32) mod d. If e ≤ 2^shift, the multiplier is m−1 with extra = 1; otherwise it is m with extra = 0.
- R8: A request accepted with `in_valid` high at one rising edge appears with `out_valid` high exactly three rising edges later. One request can be accepted per cycle, results come out in order, and `out_valid` stays low for cycles in which no request was accepted.
- R9: While `rst` is high at a rising edge, every pipeline stage is cleared: `out_valid` and `out_index` are 0 after that edge, and requests already in flight are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| in_mode | input | 2 | 00 pass, 01 modulo, 10 power-of-two divide, 11 magic divide |
| in_linear | input | 32 | Linear thread index |
| in_shift | input | 5 | Shift amount / power-of-two exponent |
| in_extra | input | 3 | Odd-factor selector (modulo) or round-down flag in bit 0 (magic) |
| in_magic | input | 32 | Division multiplier; bit 31 treated as one |
| out_valid | output | 1 | Result present |
| out_index | output | 32 | Attribute element index |

## Verification
A fixed table covers pass-through with noisy side inputs, each odd factor of the modulo mode, and shift extremes. These cases separate the wrong factor, a wrong shift placement and a truncated modulus. A random stream then mixes all four modes back to back. In it, magic divisors are spread over every magnitude, indices are drawn near 0, near the divisor and near 2^32, and bit 31 of the multiplier is set at random. Rounding, overflow or bit-31 faults show up against exact integer division there. Bubbles in the stream and a reset with requests in flight show whether the three-cycle in-order timing and the flush hold.

// File: rtl/attr_idx_pkg.sv
package attr_idx_pkg;

    localparam int IDX_W  = 32;
    localparam int SH_W   = $clog2(IDX_W);
    localparam int EXF_W  = 3;
    localparam int ODD_W  = 4;
    localparam int PROD_W = 2 * IDX_W + 1;

    typedef enum logic [1:0] {
        IM_PASS      = 2'd0,
        IM_MOD       = 2'd1,
        IM_DIV_P2    = 2'd2,
        IM_DIV_MAGIC = 2'd3
    } idx_mode_e;

    typedef struct packed {
        idx_mode_e             mode;
        logic [SH_W-1:0]       shift;
        logic [EXF_W-1:0]      extra;
        logic [IDX_W-1:0]      linear;
    } idx_req_t;

    typedef struct packed {
        idx_req_t              req;
        logic [IDX_W:0]        operand;   // index, plus one on round-down
        logic [IDX_W-1:0]      mult;      // multiplier, top bit forced
        logic [IDX_W-1:0]      upper;     // index >> shift
        logic [IDX_W-1:0]      lower;     // bits below shift
    } idx_s1_t;

    typedef struct packed {
        idx_req_t              req;
        logic [IDX_W-1:0]      upper;
        logic [IDX_W-1:0]      lower;
        logic [IDX_W-1:0]      prod_hi;
        logic [ODD_W-1:0]      odd_rem;
    } idx_s2_t;

    function automatic logic [ODD_W-1:0] odd_factor(input logic [EXF_W-1:0] e);
        case (e)
            3'd1:    return ODD_W'(3);
            3'd2:    return ODD_W'(5);
            3'd3:    return ODD_W'(7);
            3'd4:    return ODD_W'(9);
            default: return ODD_W'(1);
        endcase
    endfunction

    // Remainder of v by a small odd constant selected by e.
    function automatic logic [ODD_W-1:0] odd_mod(input logic [IDX_W-1:0] v,
                                                 input logic [EXF_W-1:0] e);
        case (e)
            3'd1:    return ODD_W'(v % IDX_W'(3));
            3'd2:    return ODD_W'(v % IDX_W'(5));
            3'd3:    return ODD_W'(v % IDX_W'(7));
            3'd4:    return ODD_W'(v % IDX_W'(9));
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/attr_idx_prep.sv
module attr_idx_prep
    import attr_idx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_v,
    input  idx_req_t         in_req,
    input  logic [IDX_W-1:0] in_magic,
    output logic             s1_v,
    output idx_s1_t          s1
);

    idx_s1_t          nxt;
    logic [IDX_W-1:0] low_mask;

    always_comb begin
        low_mask    = (IDX_W'(1) << in_req.shift) - IDX_W'(1);
        nxt.req     = in_req;
        nxt.operand = {1'b0, in_req.linear} + (IDX_W+1)'(in_req.extra[0]);
        nxt.mult    = {1'b1, in_magic[IDX_W-2:0]};
        nxt.upper   = in_req.linear >> in_req.shift;
        nxt.lower   = in_req.linear & low_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            s1   <= '0;
        end else begin
            s1_v <= in_v;
            if (in_v) s1 <= nxt;
        end
    end

    AST_S1_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (s1_v == $past(in_v)));   // R8

endmodule

// File: rtl/attr_idx_core.sv
module attr_idx_core
    import attr_idx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    s1_v,
    input  idx_s1_t s1,
    output logic    s2_v,
    output idx_s2_t s2
);

    logic [PROD_W-1:0] prod;
    idx_s2_t           nxt;

    always_comb begin
        prod         = PROD_W'(s1.operand) * PROD_W'(s1.mult);
        nxt.req      = s1.req;
        nxt.upper    = s1.upper;
        nxt.lower    = s1.lower;
        nxt.prod_hi  = prod[2*IDX_W-1:IDX_W];
        nxt.odd_rem  = odd_mod(s1.upper, s1.req.extra);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_v <= 1'b0;
            s2   <= '0;
        end else begin
            s2_v <= s1_v;
            if (s1_v) s2 <= nxt;
        end
    end

    AST_S2_FOLLOWS_S1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (s2_v == $past(s1_v)));   // R8

    AST_PROD_NOT_ABOVE_INDEX: assert property (@(posedge clk) disable iff (rst)
        (s2_v && s2.req.mode == IM_DIV_MAGIC) |-> (s2.prod_hi <= s2.req.linear));   // R5

    AST_ODD_REM_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (s2_v && s2.req.mode == IM_MOD) |-> (s2.odd_rem < odd_factor(s2.req.extra)));   // R3

endmodule

// File: rtl/attr_idx_finish.sv
module attr_idx_finish
    import attr_idx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             s2_v,
    input  idx_s2_t          s2,
    output logic             out_v,
    output logic [IDX_W-1:0] out_idx
);

    logic [IDX_W-1:0] result;

    always_comb begin
        case (s2.req.mode)
            IM_PASS:   result = s2.req.linear;
            IM_MOD:    result = (IDX_W'(s2.odd_rem) << s2.req.shift) | s2.lower;
            IM_DIV_P2: result = s2.upper;
            default:   result = s2.prod_hi >> s2.req.shift;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v   <= 1'b0;
            out_idx <= '0;
        end else begin
            out_v <= s2_v;
            if (s2_v) out_idx <= result;
        end
    end

    AST_OUT_FOLLOWS_S2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_v == $past(s2_v)));   // R8

    AST_PASS_UNCHANGED: assert property (@(posedge clk) disable iff (rst)
        (out_v && $past(s2.req.mode) == IM_PASS) |-> (out_idx == $past(s2.req.linear)));   // R1

    AST_P2_NOT_ABOVE_INDEX: assert property (@(posedge clk) disable iff (rst)
        (out_v && $past(s2.req.mode) == IM_DIV_P2) |-> (out_idx <= $past(s2.req.linear)));   // R2

    AST_MOD_BELOW_MODULUS: assert property (@(posedge clk) disable iff (rst)
        (out_v && $past(s2.req.mode) == IM_MOD) |->
        (64'(out_idx) < (64'(odd_factor($past(s2.req.extra))) << $past(s2.req.shift))));   // R3

endmodule

// File: rtl/attr_index_unit.sv
module attr_index_unit
    import attr_idx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_mode,
    input  logic [IDX_W-1:0] in_linear,
    input  logic [SH_W-1:0]  in_shift,
    input  logic [EXF_W-1:0] in_extra,
    input  logic [IDX_W-1:0] in_magic,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_index
);

    idx_req_t req;
    logic     s1_v, s2_v;
    idx_s1_t  s1;
    idx_s2_t  s2;

    always_comb begin
        req.mode   = idx_mode_e'(in_mode);
        req.shift  = in_shift;
        req.extra  = in_extra;
        req.linear = in_linear;
    end

    attr_idx_prep u_prep (
        .clk(clk), .rst(rst), .in_v(in_valid), .in_req(req),
        .in_magic(in_magic), .s1_v(s1_v), .s1(s1)
    );

    attr_idx_core u_core (
        .clk(clk), .rst(rst), .s1_v(s1_v), .s1(s1), .s2_v(s2_v), .s2(s2)
    );

    attr_idx_finish u_finish (
        .clk(clk), .rst(rst), .s2_v(s2_v), .s2(s2),
        .out_v(out_valid), .out_idx(out_index)
    );

endmodule

// File: tb/attr_index_unit_bench.sv
`timescale 1ns/1ps
module attr_index_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_mode = '0;
    logic [31:0] in_linear = '0;
    logic [4:0]  in_shift = '0;
    logic [2:0]  in_extra = '0;
    logic [31:0] in_magic = '0;
    logic        out_valid;
    logic [31:0] out_index;

    always #2 clk = ~clk;   // 250 MHz

    attr_index_unit u_attr_index_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_linear(in_linear), .in_shift(in_shift), .in_extra(in_extra),
        .in_magic(in_magic), .out_valid(out_valid), .out_index(out_index)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Expected pipeline contents, slot 2 is the one due at the output.
    bit          q_v [3];
    logic [31:0] q_d [3];
    string       q_t [3];

    typedef struct packed {
        logic [1:0]  md;
        logic [31:0] lin;
        logic [4:0]  sh;
        logic [2:0]  ex;
        logic [31:0] exp;
    } vec_t;

    localparam int NTBL = 10;
    localparam vec_t TBL [NTBL] = '{
        '{2'd0, 32'hDEADBEEF, 5'd7,  3'd3, 32'hDEADBEEF},  // R1
        '{2'd2, 32'hDEADBEEF, 5'd4,  3'd0, 32'h0DEADBEE},  // R2
        '{2'd2, 32'hFFFFFFFF, 5'd31, 3'd5, 32'd1},         // R2
        '{2'd2, 32'd12345,    5'd0,  3'd1, 32'd12345},     // R2
        '{2'd1, 32'd1000,     5'd3,  3'd4, 32'd64},        // R3 mod 72
        '{2'd1, 32'hFFFFFFFF, 5'd0,  3'd1, 32'd0},         // R3 mod 3
        '{2'd1, 32'h12345678, 5'd5,  3'd0, 32'd24},        // R3 mod 32
        '{2'd1, 32'd1234,     5'd2,  3'd2, 32'd14},        // R3 mod 20
        '{2'd1, 32'd100,      5'd0,  3'd3, 32'd2},         // R3 mod 7
        '{2'd1, 32'hFFFFFFFF, 5'd31, 3'd4, 32'hFFFFFFFF}   // R3 mod 9*2^31
    };

    task automatic check_now(input bit ok, input string tag,
                             input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: compare the due slot, advance the model, drive the next request.
    task automatic step(input bit r, input bit v, input logic [1:0] md,
                        input logic [31:0] lin, input logic [4:0] sh,
                        input logic [2:0] ex, input logic [31:0] mg,
                        input logic [31:0] exp, input string tag);
        @(negedge clk);
        if (q_v[2] || out_valid) begin
            n_chk++;
            if (out_valid !== q_v[2] || (q_v[2] && out_index !== q_d[2])) begin
                n_fail++;
                $display("FAIL %s: actual valid=%0b index=%h expected valid=%0b index=%h",
                         q_t[2], out_valid, out_index, q_v[2], q_d[2]);
            end
        end
        q_v[2] = q_v[1]; q_d[2] = q_d[1]; q_t[2] = q_t[1];
        q_v[1] = q_v[0]; q_d[1] = q_d[0]; q_t[1] = q_t[0];
        q_v[0] = v;      q_d[0] = exp;    q_t[0] = tag;
        if (r) begin
            for (int i = 0; i < 3; i++) begin q_v[i] = 1'b0; q_t[i] = "R9"; end
        end
        rst = r; in_valid = v && !r; in_mode = md; in_linear = lin;
        in_shift = sh; in_extra = ex; in_magic = mg;
    endtask

    // Magic constants following the rule in R7.
    task automatic magic_for(input logic [31:0] d, output logic [4:0] sh,
                             output logic [31:0] mg, output logic [2:0] ex);
        logic [63:0] two, m, e;
        sh = '0;
        for (int i = 0; i < 32; i++) if (d[i]) sh = 5'(i);
        two = 64'd1 << (32 + int'(sh));
        m   = (two + 64'(d) - 64'd1) / 64'(d);
        e   = two % 64'(d);
        if (e <= (64'd1 << sh)) begin m = m - 64'd1; ex = 3'd1; end
        else ex = 3'd0;
        mg = m[31:0] & 32'h7FFFFFFF;
    endtask

    task automatic magic_req(input logic [31:0] d, input logic [31:0] n,
                             input bit set31, input string tag);
        logic [4:0] sh; logic [31:0] mg; logic [2:0] ex;
        magic_for(d, sh, mg, ex);
        if (set31) mg[31] = 1'b1;
        step(1'b0, 1'b1, 2'd3, n, sh, ex, mg, n / d, tag);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin q_v[i] = 1'b0; q_d[i] = '0; q_t[i] = "R9"; end
        repeat (4) step(1'b1, 1'b0, 2'd0, '0, '0, '0, '0, '0, "R9");
        check_now(out_valid === 1'b0 && out_index === 32'd0, "R9 reset state",
                  {31'd0, out_valid} ^ out_index, 32'd0);

        // Table walk, back to back.
        for (int k = 0; k < NTBL; k++) begin
            string tg;
            tg = (TBL[k].md == 2'd0) ? "R1 pass" : (TBL[k].md == 2'd2) ? "R2 pow2" : "R3 modulo";
            step(1'b0, 1'b1, TBL[k].md, TBL[k].lin, TBL[k].sh, TBL[k].ex,
                 32'hA5A5A5A5, TBL[k].exp, tg);
        end

        // Directed magic corners.
        magic_req(32'd3, 32'hFFFFFFFF, 1'b0, "R5 d=3 max index");
        magic_req(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, "R5 d=max n=max");
        magic_req(32'hFFFFFFFF, 32'hFFFFFFFE, 1'b1, "R6 d=max n=max-1");
        magic_req(32'd7, 32'd6, 1'b0, "R4 R7 d=7 n=6");
        magic_req(32'd7, 32'd7, 1'b1, "R6 R7 d=7 n=7");
        magic_req(32'h80000001, 32'hFFFFFFFF, 1'b0, "R7 d=2^31+1");
        magic_req(32'd72, 32'd0, 1'b0, "R4 R7 zero index");

        // Bubbles between requests.
        step(1'b0, 1'b0, 2'd0, 32'h11111111, '0, '0, '0, '0, "R8 bubble");
        step(1'b0, 1'b1, 2'd2, 32'h80000000, 5'd31, '0, '0, 32'd1, "R8 R2");
        step(1'b0, 1'b0, 2'd3, 32'h22222222, '0, '0, '0, '0, "R8 bubble");
        step(1'b0, 1'b0, 2'd1, 32'h33333333, '0, '0, '0, '0, "R8 bubble");
        step(1'b0, 1'b1, 2'd0, 32'h00000042, 5'd3, 3'd2, 32'hFFFFFFFF, 32'h42, "R8 R1");

        // Mixed random stream.
        for (int it = 0; it < 1500; it++) begin
            int md;
            logic [31:0] n, d;
            logic [4:0] sh;
            logic [2:0] ex;
            logic [63:0] modulus;
            md = int'($urandom % 5);
            n  = $urandom;
            sh = 5'($urandom);
            if (md == 4) begin
                step(1'b0, 1'b0, 2'($urandom), n, sh, 3'($urandom), $urandom, '0, "R8 bubble");
            end else if (md == 0) begin
                step(1'b0, 1'b1, 2'd0, n, sh, 3'($urandom), $urandom, n, "R1 random");
            end else if (md == 1) begin
                ex = 3'($urandom % 5);
                modulus = 64'(2 * int'(ex) + 1) << sh;
                if ($urandom % 4 == 0) n = 32'hFFFFFFFF - ($urandom % 4);
                step(1'b0, 1'b1, 2'd1, n, sh, ex, $urandom, 32'(64'(n) % modulus), "R3 random");
            end else if (md == 2) begin
                step(1'b0, 1'b1, 2'd2, n, sh, 3'($urandom), $urandom, n >> sh, "R2 random");
            end else begin
                d = ($urandom >> ($urandom % 31)) | 32'd3;
                case ($urandom % 4)
                    0: n = 32'hFFFFFFFF - ($urandom % 8);
                    1: n = d - 32'd1 + ($urandom % 3);
                    2: n = $urandom % 16;
                    default: n = $urandom;
                endcase
                magic_req(d, n, 1'($urandom), "R7 R6 random");
            end
        end

        // Reset with requests in flight.
        step(1'b0, 1'b1, 2'd0, 32'h01234567, '0, '0, '0, 32'h01234567, "R1");
        step(1'b0, 1'b1, 2'd0, 32'h89ABCDEF, '0, '0, '0, 32'h89ABCDEF, "R1");
        step(1'b1, 1'b1, 2'd0, 32'h55555555, '0, '0, '0, '0, "R9");
        step(1'b0, 1'b0, 2'd0, '0, '0, '0, '0, '0, "R9");
        check_now(out_valid === 1'b0 && out_index === 32'd0, "R9 flush",
                  {31'd0, out_valid} ^ out_index, 32'd0);
        repeat (4) step(1'b0, 1'b0, 2'd0, '0, '0, '0, '0, '0, "R9 after flush");
        step(1'b0, 1'b1, 2'd2, 32'h00000100, 5'd8, '0, '0, 32'd1, "R8 R2 after flush");
        repeat (4) step(1'b0, 1'b0, 2'd0, '0, '0, '0, '0, '0, "R8 drain");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule